// File: doc/BRIEF.md
# Reversible Permutation Gate Extractor

This block turns the truth table of a reversible function into a list of gates. The function has N_VARS inputs and N_VARS outputs, with N_VARS equal to 3 or 4. The table is held as one N_VARS-bit output word per input row, and the words form a permutation of 0..2^N_VARS-1. After a start pulse, the engine first confirms that no output value appears twice. It then sweeps the rows once per pass, working on a single bit position, or variable, in each pass and moving to the next variable cyclically. Whenever a row's output disagrees with its own index on the current variable, the engine may exchange that output with the one that differs from it in that bit alone. It stops when every row's output equals its row index.

Each exchange is equivalent to a NOT on the target bit, taken at the output side, controlled by all the other bits at their shared values. The engine publishes each exchange as one gate on a strobed stream. Gates leave the block in extraction order. A consumer builds the original function by applying them in the opposite order.

The table is loaded one row at a time while the engine is idle. Results are the gate stream, a done flag for success and an error flag for a bad table or a runaway run.

Top module: `rps_engine`

## Requirements
- R1: After reset, busy, done, err and gate_valid are low, and every table row holds its own index. A start with no prior load therefore ends done with no gates.
- R2: While idle, a cycle with ld_en high writes ld_data into row ld_addr. ld_en is ignored while busy.
- R3: A start sampled while idle raises busy at the next clock edge. A start sampled while busy has no effect.
- R4: If any output value appears in two rows, the run ends with err high and done low, and no gate is emitted.
- R5: The passes work on variables 0, 1, ..., N_VARS-1 and then wrap to 0. Within a pass, rows are taken in ascending index. All visited marks are cleared when a pass begins.
- R6: In an unvisited row j whose output bit i differs from bit i of j, the engine marks row j visited. It then locates row k, whose output equals row j's output with bit i inverted. If k > j, the two outputs are exchanged and row k is marked visited.
- R7: If that partner row k lies before j, the exchange and the marking of k happen only when row k's output is not equal to k. Otherwise the row is left unchanged and no gate is emitted.
- R8: Every exchange emits exactly one gate for one cycle, in extraction order. gate_tgt is the variable index. gate_mask has every bit set except the target bit. gate_pol holds row j's output as it was before the exchange, with the target bit cleared. A 1 in gate_pol marks a positive control and a 0 marks a negative control.
- R9: At the end of each pass, the run ends done if every row holds its own index. At least one pass always runs.
- R10: If 2^N_VARS*N_VARS*4 passes complete without reaching the identity, the run ends with err high.
- R11: done and err are never high together. Both hold until the next accepted start, and both clear at that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Table row write strobe |
| ld_addr | input | N_VARS | Row index to write |
| ld_data | input | N_VARS | Output value for that row |
| start | input | 1 | Begin a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run reached the identity |
| err | output | 1 | Last run found a duplicate value or ran out of passes |
| gate_valid | output | 1 | A gate is presented this cycle |
| gate_tgt | output | max(1,clog2(N_VARS)) | Target variable index |
| gate_mask | output | N_VARS | Control mask, all bits except the target |
| gate_pol | output | N_VARS | Control polarity values |

## Verification
busy is due one edge after an accepted start and is sampled at the next falling edge. Each gate strobe comes one edge after the exchange it reports and lasts one cycle. The monitor therefore compares the stream, in order, on every falling edge where gate_valid is high, against a queue filled by a model that works from the requirements. done or err is set on the same edge that drops busy, so the outcome is sampled on the first falling edge with busy low, after the queue must have drained. Writes and a second start are injected mid-run, and a follow-up start on the resulting table shows whether they were ignored.

// File: rtl/rps_pkg.sv
// Shared types for the reversible permutation gate extractor.
package rps_pkg;
    // Controller phases of one run.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start, loads allowed
        ST_CHK,    // duplicate scan, one row per cycle
        ST_PASS,   // clear visited marks, rewind row pointer
        ST_ROW,    // examine row j
        ST_SRCH,   // linear search for the partner row
        ST_ACT,    // decide exchange, emit gate
        ST_END     // end of pass: advance variable, test identity
    } rps_state_e;
endpackage

// File: rtl/rps_table.sv
// Truth table storage: one N-bit output word per row.
// Assumes a swap and a load never coincide (the controller only loads while idle).
// Resets to the identity permutation; is_ident reports whether it still holds.
module rps_table #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_addr,
    input  logic [N-1:0] wr_data,
    input  logic         sw_en,
    input  logic [N-1:0] sw_a,
    input  logic [N-1:0] sw_b,
    input  logic [N-1:0] rd_a_addr,
    output logic [N-1:0] rd_a_data,
    input  logic [N-1:0] rd_b_addr,
    output logic [N-1:0] rd_b_data,
    output logic         is_ident
);
    localparam int ROWS = 1 << N;

    logic [N-1:0]    mem [ROWS];
    logic [ROWS-1:0] row_ok;

    // Storage update: reset to identity, exchange two rows, or load one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= N'(r);
        end else if (sw_en) begin
            mem[sw_a] <= mem[sw_b];
            mem[sw_b] <= mem[sw_a];
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];

    // Per-row home test, reduced to a single identity flag.
    for (genvar g = 0; g < ROWS; g++) begin : g_home
        assign row_ok[g] = (mem[g] == N'(g));
    end
    assign is_ident = &row_ok;
endmodule

// File: rtl/rps_visit.sv
// Visited marks for the rows of the current pass.
// Two set ports: one for the row under inspection, one for an exchanged partner.
module rps_visit #(
    parameter int N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_a,
    input  logic [N-1:0]      idx_a,
    input  logic              set_b,
    input  logic [N-1:0]      idx_b,
    output logic [(1<<N)-1:0] flags
);
    // Mark maintenance: clear at pass start, otherwise accumulate sets.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '0;
        end else begin
            if (set_a) flags[idx_a] <= 1'b1;
            if (set_b) flags[idx_b] <= 1'b1;
        end
    end
endmodule

// File: rtl/rps_gate_fmt.sv
// Gate field formatter: one-hot of the target, control mask and polarity.
// Assumes tgt < N. Polarity is the given output word with the target bit cleared.
module rps_gate_fmt #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [IW-1:0] tgt,
    input  logic [N-1:0]  val,
    output logic [N-1:0]  hot,
    output logic [N-1:0]  mask,
    output logic [N-1:0]  pol
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        assign hot[b] = (tgt == IW'(b));
    end
    assign mask = ~hot;
    assign pol  = val & mask;
endmodule

// File: rtl/rps_engine.sv
// Reversible permutation gate extractor, top level.
// Scans the table one variable per pass and exchanges single-bit partner
// outputs until the table is the identity, emitting one gate per exchange.
// Assumes loads arrive only while idle; they are dropped otherwise.
module rps_engine
    import rps_pkg::*;
#(
    parameter int N_VARS = 3
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      ld_en,
    input  logic [N_VARS-1:0]                         ld_addr,
    input  logic [N_VARS-1:0]                         ld_data,
    input  logic                                      start,
    output logic                                      busy,
    output logic                                      done,
    output logic                                      err,
    output logic                                      gate_valid,
    output logic [((N_VARS > 1) ? $clog2(N_VARS) : 1)-1:0] gate_tgt,
    output logic [N_VARS-1:0]                         gate_mask,
    output logic [N_VARS-1:0]                         gate_pol
);
    localparam int ROWS     = 1 << N_VARS;
    localparam int IW       = (N_VARS > 1) ? $clog2(N_VARS) : 1;
    localparam int MAX_PASS = ROWS * N_VARS * 4;
    localparam int PW       = $clog2(MAX_PASS + 1);

    rps_state_e          st;
    logic [N_VARS-1:0]   row_j, row_k, cur_val;
    logic [IW-1:0]       var_i;
    logic [PW-1:0]       pass_cnt;
    logic [ROWS-1:0]     seen;
    logic                done_q, err_q;
    logic                gv_q;
    logic [IW-1:0]       gt_q;
    logic [N_VARS-1:0]   gm_q, gp_q;

    logic [N_VARS-1:0]   rd_a_data, rd_b_data;
    logic                is_ident;
    logic [ROWS-1:0]     visited;
    logic [N_VARS-1:0]   tgt_hot, tgt_mask, tgt_pol;
    logic [N_VARS-1:0]   partner;
    logic                row_last, bit_ok, do_swap, var_wrap;
    logic [PW-1:0]       pass_next;

    assign partner   = cur_val ^ tgt_hot;
    assign row_last  = (row_j == N_VARS'(ROWS - 1));
    assign bit_ok    = (rd_a_data[var_i] == row_j[var_i]);
    assign do_swap   = (st == ST_ACT) && ((row_k > row_j) || (rd_b_data != row_k));
    assign var_wrap  = (var_i == IW'(N_VARS - 1));
    assign pass_next = pass_cnt + PW'(1);

    rps_table #(.N(N_VARS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ld_en && (st == ST_IDLE)),
        .wr_addr   (ld_addr),
        .wr_data   (ld_data),
        .sw_en     (do_swap),
        .sw_a      (row_j),
        .sw_b      (row_k),
        .rd_a_addr (row_j),
        .rd_a_data (rd_a_data),
        .rd_b_addr (row_k),
        .rd_b_data (rd_b_data),
        .is_ident  (is_ident)
    );

    rps_visit #(.N(N_VARS)) u_visit (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st == ST_PASS),
        .set_a ((st == ST_ROW) && !visited[row_j]),
        .idx_a (row_j),
        .set_b (do_swap),
        .idx_b (row_k),
        .flags (visited)
    );

    rps_gate_fmt #(.N(N_VARS), .IW(IW)) u_fmt (
        .tgt  (var_i),
        .val  (cur_val),
        .hot  (tgt_hot),
        .mask (tgt_mask),
        .pol  (tgt_pol)
    );

    // Run controller: duplicate scan, row passes, partner search, pass bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            row_j    <= '0;
            row_k    <= '0;
            cur_val  <= '0;
            var_i    <= '0;
            pass_cnt <= '0;
            seen     <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            gv_q     <= 1'b0;
            gt_q     <= '0;
            gm_q     <= '0;
            gp_q     <= '0;
        end else begin
            gv_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        seen   <= '0;
                        row_j  <= '0;
                        st     <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    if (seen[rd_a_data]) begin
                        err_q <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        seen[rd_a_data] <= 1'b1;
                        if (row_last) begin
                            var_i    <= '0;
                            pass_cnt <= '0;
                            st       <= ST_PASS;
                        end else begin
                            row_j <= row_j + 1'b1;
                        end
                    end
                end
                ST_PASS: begin
                    row_j <= '0;
                    st    <= ST_ROW;
                end
                ST_ROW: begin
                    if (visited[row_j] || bit_ok) begin
                        if (row_last) st <= ST_END;
                        else          row_j <= row_j + 1'b1;
                    end else begin
                        cur_val <= rd_a_data;
                        row_k   <= '0;
                        st      <= ST_SRCH;
                    end
                end
                ST_SRCH: begin
                    if (rd_b_data == partner) st <= ST_ACT;
                    else                      row_k <= row_k + 1'b1;
                end
                ST_ACT: begin
                    if (do_swap) begin
                        gv_q <= 1'b1;
                        gt_q <= var_i;
                        gm_q <= tgt_mask;
                        gp_q <= tgt_pol;
                    end
                    if (row_last) begin
                        st <= ST_END;
                    end else begin
                        row_j <= row_j + 1'b1;
                        st    <= ST_ROW;
                    end
                end
                ST_END: begin
                    pass_cnt <= pass_next;
                    var_i    <= var_wrap ? '0 : var_i + 1'b1;
                    if (is_ident) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (pass_next >= PW'(MAX_PASS)) begin
                        err_q <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        st <= ST_PASS;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign done       = done_q;
    assign err        = err_q;
    assign gate_valid = gv_q;
    assign gate_tgt   = gt_q;
    assign gate_mask  = gm_q;
    assign gate_pol   = gp_q;
endmodule

// File: rtl/rps_engine_chk.sv
// Port-level property checker for rps_engine, attached by bind.
module rps_engine_chk #(
    parameter int N_VARS = 3,
    parameter int IW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              gate_valid,
    input logic [IW-1:0]     gate_tgt,
    input logic [N_VARS-1:0] gate_mask,
    input logic [N_VARS-1:0] gate_pol
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy); // R3
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy); // R4
    AST_GATE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) gate_valid |-> busy); // R6
    AST_GATE_TGT: assert property (@(posedge clk) disable iff (!rst_n) gate_valid |-> (32'(gate_tgt) < N_VARS)); // R8
    AST_GATE_MASK: assert property (@(posedge clk) disable iff (!rst_n) gate_valid |-> (($countones(gate_mask) == N_VARS - 1) && !gate_mask[gate_tgt])); // R8
    AST_GATE_POL: assert property (@(posedge clk) disable iff (!rst_n) gate_valid |-> ((gate_pol & ~gate_mask) == '0)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R11
endmodule

bind rps_engine rps_engine_chk #(.N_VARS(N_VARS), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .gate_valid (gate_valid),
    .gate_tgt   (gate_tgt),
    .gate_mask  (gate_mask),
    .gate_pol   (gate_pol)
);

// File: tb/rps_engine_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: a requirement-level model fills the expected gate queue,
// a falling-edge monitor pops and compares each emitted gate.
module rps_engine_bench;
    localparam int N        = 3;
    localparam int ROWS     = 1 << N;
    localparam int IW       = 2;
    localparam int MAX_PASS = ROWS * N * 4;
    localparam int GW       = IW + 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [N-1:0]  ld_addr = '0;
    logic [N-1:0]  ld_data = '0;
    logic          start = 1'b0;
    logic          busy, done, err, gate_valid;
    logic [IW-1:0] gate_tgt;
    logic [N-1:0]  gate_mask, gate_pol;

    int n_checks = 0;
    int n_fail   = 0;
    logic [GW-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    rps_engine #(.N_VARS(N)) u_rps_engine (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .start(start), .busy(busy), .done(done), .err(err), .gate_valid(gate_valid),
        .gate_tgt(gate_tgt), .gate_mask(gate_mask), .gate_pol(gate_pol)
    );

    // One counted check; prints a FAIL line with actual and expected on mismatch.
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Requirement-level model: pushes expected gates, returns expected err.
    task automatic model(input int vals[ROWS], output bit e);
        int  m [ROWS];
        bit  vis [ROWS];
        bit  seenv [ROWS];
        int  vi, passes, k, v, mask, tmp;
        bit  ident;
        e = 1'b0;
        for (int r = 0; r < ROWS; r++) begin m[r] = vals[r]; seenv[r] = 1'b0; end
        for (int r = 0; r < ROWS; r++) begin
            if (seenv[m[r]]) begin e = 1'b1; return; end
            seenv[m[r]] = 1'b1;
        end
        vi = 0;
        passes = 0;
        forever begin
            for (int r = 0; r < ROWS; r++) vis[r] = 1'b0;
            for (int j = 0; j < ROWS; j++) begin
                if (!vis[j]) begin
                    vis[j] = 1'b1;
                    if (((m[j] >> vi) & 1) != ((j >> vi) & 1)) begin
                        v = m[j] ^ (1 << vi);
                        k = 0;
                        for (int q = 0; q < ROWS; q++) if (m[q] == v) k = q;
                        if (k > j || m[k] != k) begin
                            mask = ~(1 << vi) & (ROWS - 1);
                            exp_q.push_back({IW'(vi), N'(mask), N'(m[j] & mask)});
                            tmp = m[j]; m[j] = m[k]; m[k] = tmp;
                            vis[k] = 1'b1;
                        end
                    end
                end
            end
            passes++;
            vi = (vi + 1) % N;
            ident = 1'b1;
            for (int r = 0; r < ROWS; r++) if (m[r] != r) ident = 1'b0;
            if (ident) return;
            if (passes >= MAX_PASS) begin e = 1'b1; return; end
        end
    endtask

    // Monitor: compare every gate strobe against the queue head (R5/R6/R7/R8).
    always @(negedge clk) begin
        if (rst_n && gate_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected gate", int'({gate_tgt, gate_mask, gate_pol}), -1);
            end else begin
                logic [GW-1:0] e;
                e = exp_q.pop_front();
                check("R5/R6/R7/R8 gate", int'({gate_tgt, gate_mask, gate_pol}), int'(e));
            end
        end
    end

    task automatic load(input int vals[ROWS]);
        for (int r = 0; r < ROWS; r++) begin
            ld_en = 1'b1; ld_addr = N'(r); ld_data = N'(vals[r]);
            @(negedge clk);
        end
        ld_en = 1'b0;
    endtask

    // Start a run, optionally inject a load and a start mid-run, check outcome.
    task automatic run(input string name, input int vals[ROWS], input bit do_load,
                       input bit inject);
        bit e;
        int waited;
        if (do_load) load(vals);
        model(vals, e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({name, " R3 busy after start"}, int'(busy), 1);
        check({name, " R11 flags cleared at start"}, int'(done | err), 0);
        if (inject) begin
            repeat (3) @(negedge clk);
            ld_en = 1'b1; ld_addr = '0; ld_data = N'(5); start = 1'b1;
            @(negedge clk);
            ld_en = 1'b0; start = 1'b0;
        end
        waited = 0;
        while (busy && waited < 5000) begin @(negedge clk); waited++; end
        check({name, " R9/R10 run finished"}, int'(busy), 0);
        check({name, " R4/R9/R10 err"}, int'(err), int'(e));
        check({name, " R9 done"}, int'(done), int'(!e));
        check({name, " R8 all gates emitted"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (3) @(negedge clk);
        check({name, " R11 flags held"}, int'({done, err}), int'({!e, e}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        check("R1 gate_valid", int'(gate_valid), 0);
        // R1 table resets to identity: start without load gives done, no gates
        run("identity", '{0, 1, 2, 3, 4, 5, 6, 7}, 1'b0, 1'b0);
        // R2 loads and R5/R6/R7 behaviour across several tables
        run("pairs", '{1, 0, 3, 2, 5, 7, 4, 6}, 1'b1, 1'b0);
        run("rotate", '{7, 0, 1, 2, 3, 4, 5, 6}, 1'b1, 1'b0);
        run("one_swap", '{0, 1, 2, 3, 4, 6, 5, 7}, 1'b1, 1'b0);
        run("mixed_a", '{3, 6, 2, 5, 7, 1, 0, 4}, 1'b1, 1'b0);
        run("mixed_b", '{4, 3, 0, 2, 7, 5, 6, 1}, 1'b1, 1'b0);
        // R4 duplicate value
        run("dup", '{0, 0, 2, 3, 4, 5, 6, 7}, 1'b1, 1'b0);
        // R2/R3 load and start during busy ignored
        run("inject", '{1, 2, 7, 5, 6, 3, 0, 4}, 1'b1, 1'b1);
        // R2 table left as identity by previous run: an accepted mid-run write would show here
        run("after_inject", '{0, 1, 2, 3, 4, 5, 6, 7}, 1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule